// File: doc/BRIEF.md
# Sampling-Clock Tuning Sweep Controller

This block finds a safe read-sampling phase for a high-speed card bus. It first decides whether tuning is needed at all: only the two fast timing modes above 100 MHz require it. It then brings the delay line up from reset, writing a frequency-band code that matches the bus clock, and waits for the delay line to report lock. Next it walks through all sixteen output phases in ascending order. At each phase it asks an external command engine to run one tuning-block transfer and records whether that transfer passed.

The resulting 16-bit pass mask goes to a window selector. The selector finds the longest run of consecutive passing phases, treating phase 15 and phase 0 as neighbours, and picks a point three quarters of the way into that run. The chosen phase is then programmed as the final setting. If a sweep produces no passing phase, the controller re-initialises the delay line and sweeps again, up to a fixed number of attempts.

The delay-line control word is presented on `dll_cfg`; the field positions listed below are what the analog delay line decodes. Each phase change uses a handshake: the clock output is turned off, the controller waits for the status to confirm, the new phase is written, the clock output is turned back on, and the controller waits for confirmation again.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: On `start`, if `bus_mhz` is 100 or less, or `timing_mode` is neither 1 (HS200) nor 2 (SDR104), `done` is high in the cycle after `start` with `err_code` 0. In that case `test_req` never pulses and `dll_cfg` is unchanged.
- R2: Each delay-line initialisation clears `clk_pwrsave` first. It then sets reset (bit 30), sets power-down (bit 29), releases reset while power-down is still set, releases power-down, sets DLL enable (bit 16), and finally sets clock-output enable (bit 18). Each step is a separate cycle.
- R3: The band field `dll_cfg[26:24]` written during initialisation is 0 for ≤112 MHz, 1 for ≤125, 2 for ≤137, 3 for ≤150, 4 for ≤162, 5 for ≤175, 6 for ≤187, 7 for ≤200, and 0 above 200 MHz. It already holds this value when reset is released.
- R4: After initialisation the controller polls `dll_lock` every `POLL_CYCLES` cycles. If lock is not seen within `POLL_LIMIT` polls, it ends with `err_code` 1 and runs no tests.
- R5: An attempt issues exactly 16 one-cycle `test_req` pulses for phases 0,1,…,15 in that order. During each pulse, `dll_cfg[23:20]` holds the Gray code of the phase (p ^ (p>>1)), bits 18 and 17 are set, bit 19 is clear, and `clk_pwrsave` is 0. `pass_mask[p]` takes the `test_pass` value returned for phase p.
- R6: A phase change clears bits 17 and 18, sets bits 19 and 16, waits until `ckout_stat` is 0, writes the phase field, sets bit 18, and waits until `ckout_stat` is 1. It then sets bit 17 and clears bit 19. If either wait exceeds `POLL_LIMIT` polls, the run ends with `err_code` 2.
- R7: The chosen phase comes from the longest run of consecutive passing phases. When phases 0 and 15 both pass and not all phases pass, the run holding 0 is joined onto the run holding 15. Among runs of equal length the lowest-starting one wins, with the joined run ranked by its phase-15 part. The offset into the run is floor(3·len/4) minus one (kept at 0 when it is 0), taken modulo 16.
- R8: A sweep with no passing phase restarts from initialisation. After `MAX_TRIES` (3) attempts with no pass, the run ends with `err_code` 4.
- R9: On success, `tuned_phase` holds the chosen phase and `err_code` is 0. `dll_cfg` holds its Gray code in bits 23:20 with bits 18 and 17 set and bit 19 clear. `done` is a single-cycle pulse.
- R10: With `TEST_WDOG` > 0, a `test_req` left unanswered for `TEST_WDOG` cycles ends the run with `err_code` 5.
- R11: After reset, `dll_cfg` is 0, `clk_pwrsave` is 1, and `busy`, `done` and `test_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a tuning run |
| bus_mhz | input | FREQ_W | Bus clock frequency in MHz |
| timing_mode | input | 2 | 0 legacy, 1 HS200, 2 SDR104, 3 other |
| dll_lock | input | 1 | Delay-line lock status |
| ckout_stat | input | 1 | Read-back of the delay-line clock-output enable |
| test_done | input | 1 | Tuning transfer finished (one-cycle pulse) |
| test_pass | input | 1 | Result of the transfer, valid with `test_done` |
| test_req | output | 1 | One-cycle request for a tuning transfer |
| dll_cfg | output | 32 | Delay-line control word |
| clk_pwrsave | output | 1 | Clock power-save enable, cleared while tuning |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 3 | 0 ok, 1 lock timeout, 2 phase timeout, 3 selection error, 4 no pass, 5 test timeout |
| tuned_phase | output | 4 | Selected phase |
| pass_mask | output | 16 | Per-phase results of the last sweep |

## Verification
The bench targets the wrap-around window, where a selector that ignores the join would return a phase from the wrong run. It also covers the modulo step when the three-quarter point crosses phase 15, and a tie between equal runs, where the wrong order picks the later run. Frequencies at 101, 113, 150, 200 and 250 MHz exercise the band boundaries, including the drop to 0 above 200 MHz. Failure runs cover a retry that succeeds on the third sweep, three empty sweeps, a delay line that never locks, a stuck clock-output status and a silent command engine. A design with a wrong retry count or wrong error mapping shows a different `err_code` or a different count of initialisations and requests.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam int CFG_W    = 32;
    localparam int NPH      = 16;
    localparam int PH_W     = 4;

    // control word field positions decoded by the delay line
    localparam int B_DLL_EN  = 16;
    localparam int B_CDR_EN  = 17;
    localparam int B_CKO     = 18;
    localparam int B_CDR_EXT = 19;
    localparam int B_SEL_LO  = 20;
    localparam int B_BAND_LO = 24;
    localparam int B_PDN     = 29;
    localparam int B_RST     = 30;

    typedef enum logic [1:0] {
        TM_LEGACY = 2'd0,
        TM_HS200  = 2'd1,
        TM_SDR104 = 2'd2,
        TM_OTHER  = 2'd3
    } tmode_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_LOCK    = 3'd1,
        ERR_PHASE   = 3'd2,
        ERR_SELECT  = 3'd3,
        ERR_NOPASS  = 3'd4,
        ERR_TEST_TO = 3'd5
    } terr_e;

    // one read-modify-write of the control word
    typedef struct packed {
        logic             wr;
        logic [CFG_W-1:0] set;
        logic [CFG_W-1:0] clr;
    } cfg_wr_t;

    function automatic logic [PH_W-1:0] gray4(input logic [PH_W-1:0] p);
        return p ^ (p >> 1);
    endfunction

    function automatic logic [2:0] band_of(input int unsigned mhz);
        if      (mhz <= 112) return 3'd0;
        else if (mhz <= 125) return 3'd1;
        else if (mhz <= 137) return 3'd2;
        else if (mhz <= 150) return 3'd3;
        else if (mhz <= 162) return 3'd4;
        else if (mhz <= 175) return 3'd5;
        else if (mhz <= 187) return 3'd6;
        else if (mhz <= 200) return 3'd7;
        else                 return 3'd0;
    endfunction

endpackage

// File: rtl/tune_poll.sv
module tune_poll #(
    parameter int INTERVAL = 50,
    parameter int LIMIT    = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cond,
    output logic ok,
    output logic tmo
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL + 1) : 1;
    localparam int LW = $clog2(LIMIT + 1);

    logic          active;
    logic [IW-1:0] wait_q;
    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wait_q <= '0;
            left_q <= '0;
            ok     <= 1'b0;
            tmo    <= 1'b0;
        end else begin
            ok  <= 1'b0;
            tmo <= 1'b0;
            if (start) begin
                active <= 1'b1;
                wait_q <= '0;
                left_q <= LW'(LIMIT);
            end else if (active) begin
                if (wait_q != '0) begin
                    wait_q <= wait_q - 1'b1;
                end else if (cond) begin
                    ok     <= 1'b1;
                    active <= 1'b0;
                end else if (left_q <= LW'(1)) begin
                    tmo    <= 1'b1;
                    active <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                    wait_q <= IW'(INTERVAL - 1);
                end
            end
        end
    end

    // R4 / R6: success only follows an observed condition
    p_ok_needs_cond_r4: assert property (@(posedge clk) disable iff (rst)
        ok |-> $past(cond));

endmodule

// File: rtl/tune_phase_prog.sv
module tune_phase_prog
    import tune_pkg::*;
#(
    parameter int POLL_CYCLES = 50,
    parameter int POLL_LIMIT  = 50
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PH_W-1:0] phase,
    input  logic            ckout_stat,
    output cfg_wr_t         wr,
    output logic            done,
    output logic            err
);
    typedef enum logic [3:0] {
        P_IDLE, P_QUIESCE, P_POLL_LO, P_WAIT_LO, P_SEL,
        P_CKO, P_POLL_HI, P_WAIT_HI, P_LOCKIN
    } pstate_e;

    pstate_e         st;
    logic [PH_W-1:0] ph_q;
    logic            poll_ok, poll_tmo, poll_cond, poll_start;

    assign poll_start = (st == P_POLL_LO) || (st == P_POLL_HI);
    assign poll_cond  = (st == P_WAIT_HI) ? ckout_stat : !ckout_stat;

    tune_poll #(.INTERVAL(POLL_CYCLES), .LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .start(poll_start), .cond(poll_cond),
        .ok(poll_ok), .tmo(poll_tmo)
    );

    always_comb begin
        wr = '0;
        case (st)
            P_QUIESCE: begin
                wr.wr = 1'b1;
                wr.clr[B_CDR_EN]  = 1'b1;
                wr.clr[B_CKO]     = 1'b1;
                wr.set[B_CDR_EXT] = 1'b1;
                wr.set[B_DLL_EN]  = 1'b1;
            end
            P_SEL: begin
                wr.wr = 1'b1;
                wr.clr[B_SEL_LO +: PH_W] = '1;
                wr.set[B_SEL_LO +: PH_W] = gray4(ph_q);
            end
            P_CKO: begin
                wr.wr = 1'b1;
                wr.set[B_CKO] = 1'b1;
            end
            P_LOCKIN: begin
                wr.wr = 1'b1;
                wr.set[B_CDR_EN]  = 1'b1;
                wr.clr[B_CDR_EXT] = 1'b1;
            end
            default: wr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= P_IDLE;
            ph_q <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                P_IDLE:    if (start) begin ph_q <= phase; st <= P_QUIESCE; end
                P_QUIESCE: st <= P_POLL_LO;
                P_POLL_LO: st <= P_WAIT_LO;
                P_WAIT_LO: begin
                    if (poll_ok)  st <= P_SEL;
                    if (poll_tmo) begin done <= 1'b1; err <= 1'b1; st <= P_IDLE; end
                end
                P_SEL:     st <= P_CKO;
                P_CKO:     st <= P_POLL_HI;
                P_POLL_HI: st <= P_WAIT_HI;
                P_WAIT_HI: begin
                    if (poll_ok)  st <= P_LOCKIN;
                    if (poll_tmo) begin done <= 1'b1; err <= 1'b1; st <= P_IDLE; end
                end
                P_LOCKIN:  begin done <= 1'b1; st <= P_IDLE; end
                default:   st <= P_IDLE;
            endcase
        end
    end

    // R6: a clean finish requires the output-enable status to have been seen high
    p_finish_after_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(st == P_LOCKIN));

endmodule

// File: rtl/tune_win_sel.sv
module tune_win_sel
    import tune_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NPH-1:0]  mask_i,
    output logic            done,
    output logic            err,
    output logic [PH_W-1:0] phase_o
);
    localparam int LW = PH_W + 1;

    logic [NPH:0]    ext;
    logic [LW-1:0]   lead_c, run_len_c, len_c, best_len_c;
    logic [PH_W-1:0] run_start_c, best_start_c, idx_c, pick_c;
    logic [LW+1:0]   prod_c;
    logic            stop_c, wrap_c;

    assign ext = {1'b0, mask_i};

    always_comb begin
        lead_c = '0;
        stop_c = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            if (mask_i[i] && !stop_c) lead_c = lead_c + 1'b1;
            else                       stop_c = 1'b1;
        end
        wrap_c       = mask_i[0] && mask_i[NPH-1] && (mask_i != '1);
        run_len_c    = '0;
        run_start_c  = '0;
        len_c        = '0;
        best_len_c   = '0;
        best_start_c = '0;
        for (int i = 0; i < NPH; i++) begin
            if (mask_i[i]) begin
                if (run_len_c == '0) run_start_c = PH_W'(i);
                run_len_c = run_len_c + 1'b1;
                if (!ext[i+1]) begin
                    len_c = run_len_c;
                    if (wrap_c && run_start_c == '0) len_c = '0;
                    if (wrap_c && i == NPH-1)        len_c = run_len_c + lead_c;
                    if (len_c > best_len_c) begin
                        best_len_c   = len_c;
                        best_start_c = run_start_c;
                    end
                    run_len_c = '0;
                end
            end
        end
        prod_c = (LW+2)'(best_len_c) * (LW+2)'(3);
        idx_c  = PH_W'(prod_c >> 2);
        if (idx_c != '0) idx_c = idx_c - 1'b1;
        pick_c = best_start_c + idx_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            err     <= 1'b0;
            phase_o <= '0;
        end else begin
            done <= start;
            if (start) begin
                err     <= (mask_i == '0);
                phase_o <= pick_c;
            end
        end
    end

    // R7: a chosen phase always lies on a passing phase
    p_pick_in_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> mask_i[phase_o]);

endmodule

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl
    import tune_pkg::*;
#(
    parameter int FREQ_W      = 9,
    parameter int GATE_MHZ    = 100,
    parameter int POLL_CYCLES = 50,
    parameter int POLL_LIMIT  = 50,
    parameter int MAX_TRIES   = 3,
    parameter int TEST_WDOG   = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] bus_mhz,
    input  logic [1:0]        timing_mode,
    input  logic              dll_lock,
    input  logic              ckout_stat,
    input  logic              test_done,
    input  logic              test_pass,
    output logic              test_req,
    output logic [31:0]       dll_cfg,
    output logic              clk_pwrsave,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic [3:0]        tuned_phase,
    output logic [15:0]       pass_mask
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int WW = (TEST_WDOG > 1) ? $clog2(TEST_WDOG + 1) : 1;

    typedef enum logic [4:0] {
        T_IDLE, T_PS, T_RST, T_PDN, T_BAND, T_URST, T_UPDN, T_EN, T_CKO,
        T_LOCK_POLL, T_LOCK_WAIT, T_PROG, T_PROG_WAIT, T_REQ, T_RESP,
        T_SEL, T_SEL_WAIT, T_FIN_PROG, T_FIN_WAIT
    } tstate_e;

    tstate_e         st;
    logic [CFG_W-1:0] cfg_q;
    logic            pwrsave_q, done_q;
    terr_e           err_q;
    logic [2:0]      band_q;
    logic [PH_W-1:0] phase_q, tuned_q;
    logic [NPH-1:0]  mask_q, mask_nx;
    logic [TW-1:0]   tries_q;
    logic [WW-1:0]   wdog_q;
    tmode_e          mode;

    cfg_wr_t         top_wr, prog_wr, apply_wr;
    logic            lock_ok, lock_tmo;
    logic            prog_start, prog_done, prog_err;
    logic            sel_done, sel_err;
    logic [PH_W-1:0] sel_phase;
    logic            need_tune;

    assign mode      = tmode_e'(timing_mode);
    assign need_tune = (bus_mhz > FREQ_W'(GATE_MHZ)) &&
                       (mode == TM_HS200 || mode == TM_SDR104);
    assign mask_nx   = mask_q | (NPH'(test_pass) << phase_q);

    tune_poll #(.INTERVAL(POLL_CYCLES), .LIMIT(POLL_LIMIT)) u_lock_poll (
        .clk(clk), .rst(rst), .start(st == T_LOCK_POLL), .cond(dll_lock),
        .ok(lock_ok), .tmo(lock_tmo)
    );

    assign prog_start = (st == T_PROG) || (st == T_FIN_PROG);

    tune_phase_prog #(.POLL_CYCLES(POLL_CYCLES), .POLL_LIMIT(POLL_LIMIT)) u_prog (
        .clk(clk), .rst(rst), .start(prog_start),
        .phase((st == T_FIN_PROG) ? tuned_q : phase_q),
        .ckout_stat(ckout_stat), .wr(prog_wr), .done(prog_done), .err(prog_err)
    );

    tune_win_sel u_sel (
        .clk(clk), .rst(rst), .start(st == T_SEL), .mask_i(mask_q),
        .done(sel_done), .err(sel_err), .phase_o(sel_phase)
    );

    // initialisation writes, one field change per cycle
    always_comb begin
        top_wr = '0;
        case (st)
            T_RST:  begin top_wr.wr = 1'b1; top_wr.set[B_RST] = 1'b1; end
            T_PDN:  begin top_wr.wr = 1'b1; top_wr.set[B_PDN] = 1'b1; end
            T_BAND: begin
                top_wr.wr = 1'b1;
                top_wr.clr[B_BAND_LO +: 3] = '1;
                top_wr.set[B_BAND_LO +: 3] = band_q;
            end
            T_URST: begin top_wr.wr = 1'b1; top_wr.clr[B_RST]    = 1'b1; end
            T_UPDN: begin top_wr.wr = 1'b1; top_wr.clr[B_PDN]    = 1'b1; end
            T_EN:   begin top_wr.wr = 1'b1; top_wr.set[B_DLL_EN] = 1'b1; end
            T_CKO:  begin top_wr.wr = 1'b1; top_wr.set[B_CKO]    = 1'b1; end
            default: top_wr = '0;
        endcase
        apply_wr = prog_wr.wr ? prog_wr : top_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)              cfg_q <= '0;
        else if (apply_wr.wr) cfg_q <= (cfg_q & ~apply_wr.clr) | apply_wr.set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            pwrsave_q <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= ERR_NONE;
            band_q    <= '0;
            phase_q   <= '0;
            tuned_q   <= '0;
            mask_q    <= '0;
            tries_q   <= '0;
            wdog_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    band_q  <= band_of(int'(bus_mhz));
                    tries_q <= '0;
                    if (need_tune) begin
                        st <= T_PS;
                    end else begin
                        done_q <= 1'b1;
                        err_q  <= ERR_NONE;
                    end
                end
                T_PS: begin
                    pwrsave_q <= 1'b0;
                    mask_q    <= '0;
                    phase_q   <= '0;
                    st        <= T_RST;
                end
                T_RST:       st <= T_PDN;
                T_PDN:       st <= T_BAND;
                T_BAND:      st <= T_URST;
                T_URST:      st <= T_UPDN;
                T_UPDN:      st <= T_EN;
                T_EN:        st <= T_CKO;
                T_CKO:       st <= T_LOCK_POLL;
                T_LOCK_POLL: st <= T_LOCK_WAIT;
                T_LOCK_WAIT: begin
                    if (lock_ok) st <= T_PROG;
                    if (lock_tmo) begin
                        done_q <= 1'b1; err_q <= ERR_LOCK; st <= T_IDLE;
                    end
                end
                T_PROG:      st <= T_PROG_WAIT;
                T_PROG_WAIT: if (prog_done) begin
                    if (prog_err) begin
                        done_q <= 1'b1; err_q <= ERR_PHASE; st <= T_IDLE;
                    end else begin
                        st <= T_REQ;
                    end
                end
                T_REQ: begin
                    wdog_q <= '0;
                    st     <= T_RESP;
                end
                T_RESP: begin
                    if (test_done) begin
                        mask_q <= mask_nx;
                        if (phase_q != PH_W'(NPH-1)) begin
                            phase_q <= phase_q + 1'b1;
                            st      <= T_PROG;
                        end else if (mask_nx != '0) begin
                            st <= T_SEL;
                        end else if (tries_q + 1'b1 < TW'(MAX_TRIES)) begin
                            tries_q <= tries_q + 1'b1;
                            st      <= T_PS;
                        end else begin
                            done_q <= 1'b1; err_q <= ERR_NOPASS; st <= T_IDLE;
                        end
                    end else if (TEST_WDOG > 0) begin
                        if (wdog_q == WW'(TEST_WDOG - 1)) begin
                            done_q <= 1'b1; err_q <= ERR_TEST_TO; st <= T_IDLE;
                        end else begin
                            wdog_q <= wdog_q + 1'b1;
                        end
                    end
                end
                T_SEL:      st <= T_SEL_WAIT;
                T_SEL_WAIT: if (sel_done) begin
                    if (sel_err) begin
                        done_q <= 1'b1; err_q <= ERR_SELECT; st <= T_IDLE;
                    end else begin
                        tuned_q <= sel_phase;
                        st      <= T_FIN_PROG;
                    end
                end
                T_FIN_PROG: st <= T_FIN_WAIT;
                T_FIN_WAIT: if (prog_done) begin
                    done_q <= 1'b1;
                    err_q  <= prog_err ? ERR_PHASE : ERR_NONE;
                    st     <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign test_req    = (st == T_REQ);
    assign dll_cfg     = cfg_q;
    assign clk_pwrsave = pwrsave_q;
    assign busy        = (st != T_IDLE);
    assign done        = done_q;
    assign err_code    = err_q;
    assign tuned_phase = tuned_q;
    assign pass_mask   = mask_q;

    // R2: power-down is raised only while reset is held
    p_pdn_under_rst_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_cfg[B_PDN]) |-> dll_cfg[B_RST]);
    // R2: reset is released while power-down still holds
    p_rst_release_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(dll_cfg[B_RST]) |-> dll_cfg[B_PDN]);
    // R5: request is a single-cycle pulse
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        test_req |=> !test_req);
    // R5: requests only with the sampling clock running and power-save off
    p_req_clock_on_r5: assert property (@(posedge clk) disable iff (rst)
        test_req |-> (dll_cfg[B_CKO] && dll_cfg[B_CDR_EN] && !dll_cfg[B_CDR_EXT] && !clk_pwrsave));
    // R9: end-of-run is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tune_sweep_ctrl_tb_top.sv
module tune_sweep_ctrl_tb_top;
    import tune_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1, start = 1'b0;
    logic [8:0]  bus_mhz = '0;
    logic [1:0]  timing_mode = '0;
    logic        dll_lock = 1'b0, ckout_stat = 1'b0, test_done = 1'b0, test_pass = 1'b0;
    logic        test_req, clk_pwrsave, busy, done;
    logic [31:0] dll_cfg;
    logic [2:0]  err_code;
    logic [3:0]  tuned_phase;
    logic [15:0] pass_mask;

    tune_sweep_ctrl #(.FREQ_W(9), .POLL_CYCLES(4), .POLL_LIMIT(50),
                      .MAX_TRIES(3), .TEST_WDOG(200)) dut_i (
        .clk(clk), .rst(rst), .start(start), .bus_mhz(bus_mhz),
        .timing_mode(timing_mode), .dll_lock(dll_lock), .ckout_stat(ckout_stat),
        .test_done(test_done), .test_pass(test_pass), .test_req(test_req),
        .dll_cfg(dll_cfg), .clk_pwrsave(clk_pwrsave), .busy(busy), .done(done),
        .err_code(err_code), .tuned_phase(tuned_phase), .pass_mask(pass_mask)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // environment knobs
    logic [15:0] pat [3];
    int  lock_dly = 3;
    bit  ck_stuck = 0, card_mute = 0;
    int  inits = 0, tests = 0, stage = 0, nxt_ph = 0, exp_band = 0;

    function automatic int gdec(input logic [3:0] g);
        int b = 0;
        for (int k = 3; k >= 0; k--) b = (b << 1) | (((b & 1) ^ int'(g[k])) & 1);
        return b;
    endfunction

    function automatic int ref_band(input int mhz);
        int edges[8] = '{112, 125, 137, 150, 162, 175, 187, 200};
        for (int k = 0; k < 8; k++) if (mhz <= edges[k]) return k;
        return 0;
    endfunction

    function automatic int ref_pick(input logic [15:0] m);
        int st[$], ln[$];
        int i = 0, s = 0, bl = 0, bs = 0, idx = 0;
        while (i < 16) begin
            if (m[i]) begin
                s = i;
                while (i < 16 && m[i]) i++;
                st.push_back(s); ln.push_back(i - s);
            end else i++;
        end
        if (st.size() > 1 && st[0] == 0 && st[st.size()-1] + ln[ln.size()-1] == 16) begin
            ln[ln.size()-1] += ln[0];
            void'(st.pop_front()); void'(ln.pop_front());
        end
        foreach (ln[k]) if (ln[k] > bl) begin bl = ln[k]; bs = st[k]; end
        idx = (bl * 3) / 4;
        if (idx != 0) idx--;
        return (bs + idx) % 16;
    endfunction

    // delay line and command engine model
    logic ck_d1 = 1'b0;
    int   lock_cnt = 0, resp_cnt = 0;
    logic [3:0] req_ph = '0;
    always @(posedge clk) begin
        ck_d1      <= dll_cfg[B_CKO];
        ckout_stat <= ck_stuck ? 1'b0 : ck_d1;
        if (dll_cfg[B_RST] || dll_cfg[B_PDN] || !dll_cfg[B_DLL_EN]) lock_cnt <= 0;
        else if (lock_cnt < 1000000) lock_cnt <= lock_cnt + 1;
        dll_lock  <= (lock_cnt >= lock_dly);
        test_done <= 1'b0;
        test_pass <= 1'b0;
        if (test_req) begin
            req_ph   <= 4'(gdec(dll_cfg[B_SEL_LO +: 4]));
            resp_cnt <= 3;
        end else if (resp_cnt > 0) begin
            resp_cnt <= resp_cnt - 1;
            if (resp_cnt == 1 && !card_mute) begin
                test_done <= 1'b1;
                test_pass <= pat[(inits < 1) ? 0 : ((inits > 3) ? 2 : inits - 1)][req_ph];
            end
        end
    end

    // every-cycle sequence monitor
    logic [31:0] prev_cfg = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (dll_cfg[B_RST] && !prev_cfg[B_RST]) begin
                inits++;
                chk(stage == 0 && !clk_pwrsave, "R2 reset-first", stage, 0);
                stage = 1; nxt_ph = 0;
            end
            if (dll_cfg[B_PDN] && !prev_cfg[B_PDN]) begin
                chk(stage == 1 && dll_cfg[B_RST], "R2 pdn-after-rst", stage, 1);
                stage = 2;
            end
            if (!dll_cfg[B_RST] && prev_cfg[B_RST]) begin
                chk(stage == 2 && dll_cfg[B_PDN], "R2 rst-release", stage, 2);
                chk(int'(dll_cfg[B_BAND_LO +: 3]) == exp_band, "R3 band",
                    int'(dll_cfg[B_BAND_LO +: 3]), exp_band);
                stage = 3;
            end
            if (!dll_cfg[B_PDN] && prev_cfg[B_PDN]) begin
                chk(stage == 3, "R2 pdn-release", stage, 3);
                stage = 4;
            end
            if (dll_cfg[B_CKO] && !prev_cfg[B_CKO] && stage == 4) begin
                chk(dll_cfg[B_DLL_EN] == 1'b1, "R2 enable-before-ckout", 0, 1);
                stage = 0;
            end
            if (test_req) begin
                tests++;
                chk(gdec(dll_cfg[B_SEL_LO +: 4]) == nxt_ph, "R5 phase order",
                    gdec(dll_cfg[B_SEL_LO +: 4]), nxt_ph);
                nxt_ph++;
            end
            prev_cfg = dll_cfg;
        end
    end

    // global watchdog
    int cyc_all = 0;
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    int lat;
    task automatic run(input int mhz, input int md, input logic [15:0] p0,
                       input logic [15:0] p1, input logic [15:0] p2,
                       input int ldly, input bit stuck, input bit mute);
        @(negedge clk);
        bus_mhz = 9'(mhz); timing_mode = 2'(md);
        pat[0] = p0; pat[1] = p1; pat[2] = p2;
        lock_dly = ldly; ck_stuck = stuck; card_mute = mute;
        inits = 0; tests = 0; stage = 0;
        exp_band = ref_band(mhz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20000) begin @(negedge clk); lat++; end
        chk(done == 1'b1, "run-complete", int'(done), 1);
    endtask

    task automatic expect_ok(input string tag, input logic [15:0] m, input int att);
        int ep = ref_pick(m);
        chk(err_code == 3'd0, {tag, " R9 err"}, int'(err_code), 0);
        chk(int'(tuned_phase) == ep, {tag, " R7 phase"}, int'(tuned_phase), ep);
        chk(pass_mask == m, {tag, " R5 mask"}, int'(pass_mask), int'(m));
        chk(int'(dll_cfg[B_SEL_LO +: 4]) == int'(gray4(4'(ep))), {tag, " R9 cfg phase"},
            int'(dll_cfg[B_SEL_LO +: 4]), int'(gray4(4'(ep))));
        chk(dll_cfg[B_CKO] && dll_cfg[B_CDR_EN] && !dll_cfg[B_CDR_EXT], {tag, " R6 final bits"},
            int'(dll_cfg[19:17]), 3);
        chk(tests == 16 * att, {tag, " R5 test count"}, tests, 16 * att);
        chk(inits == att, {tag, " R8 attempts"}, inits, att);
        @(negedge clk);
        chk(!done, {tag, " R9 done pulse"}, int'(done), 0);
    endtask

    initial begin
        pat[0] = '0; pat[1] = '0; pat[2] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(dll_cfg == 32'd0, "R11 cfg", int'(dll_cfg), 0);
        chk(clk_pwrsave == 1'b1, "R11 pwrsave", int'(clk_pwrsave), 1);
        chk(!busy && !done && !test_req, "R11 idle", int'({busy, done, test_req}), 0);
        rst = 1'b0;

        // R1 gate: low clock, legacy mode, other mode
        run(100, 1, 16'hFFFF, 0, 0, 3, 0, 0);
        chk(lat == 1 && err_code == 0 && tests == 0 && dll_cfg == 0, "R1 low clock", lat, 1);
        run(200, 0, 16'hFFFF, 0, 0, 3, 0, 0);
        chk(lat == 1 && err_code == 0 && tests == 0 && dll_cfg == 0, "R1 legacy", lat, 1);
        run(200, 3, 16'hFFFF, 0, 0, 3, 0, 0);
        chk(lat == 1 && tests == 0 && clk_pwrsave, "R1 other mode", lat, 1);

        // R3/R5/R7/R9 successful sweeps
        run(150, 2, 16'h00F0, 0, 0, 3, 0, 0);  expect_ok("plain run", 16'h00F0, 1);
        run(113, 1, 16'hE003, 0, 0, 3, 0, 0);  expect_ok("wrap", 16'hE003, 1);
        run(200, 2, 16'hC007, 0, 0, 3, 0, 0);  expect_ok("wrap modulo", 16'hC007, 1);
        run(101, 1, 16'hFFFF, 0, 0, 3, 0, 0);  expect_ok("all pass", 16'hFFFF, 1);
        run(125, 2, 16'h0303, 0, 0, 3, 0, 0);  expect_ok("tie", 16'h0303, 1);
        run(187, 1, 16'h8181, 0, 0, 3, 0, 0);  expect_ok("tie with wrap", 16'h8181, 1);
        run(162, 2, 16'h0020, 0, 0, 3, 0, 0);  expect_ok("single", 16'h0020, 1);
        run(250, 1, 16'h0F00, 0, 0, 3, 0, 0);  expect_ok("R3 above top band", 16'h0F00, 1);

        // R8 retry then success, and exhaustion
        run(137, 2, 16'h0000, 16'h0000, 16'h0180, 3, 0, 0);
        expect_ok("R8 retry", 16'h0180, 3);
        run(175, 1, 16'h0000, 16'h0000, 16'h0000, 3, 0, 0);
        chk(err_code == 3'd4, "R8 no pass err", int'(err_code), 4);
        chk(inits == 3 && tests == 48, "R8 no pass attempts", inits, 3);

        // R4 lock timeout
        run(150, 1, 16'hFFFF, 0, 0, 100000000, 0, 0);
        chk(err_code == 3'd1, "R4 lock timeout", int'(err_code), 1);
        chk(tests == 0 && inits == 1, "R4 no tests", tests, 0);

        // R6 stuck output-enable status
        run(150, 1, 16'hFFFF, 0, 0, 3, 1, 0);
        chk(err_code == 3'd2, "R6 phase timeout", int'(err_code), 2);
        chk(tests == 0, "R6 no tests", tests, 0);

        // R10 silent command engine
        run(150, 2, 16'hFFFF, 0, 0, 3, 0, 1);
        chk(err_code == 3'd5, "R10 test timeout", int'(err_code), 5);
        chk(tests == 1, "R10 one request", tests, 1);
        card_mute = 0;

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule